// File: doc/BRIEF.md
# Memory-Mapped 64-bit Real-Time Counter

This peripheral keeps a 64-bit time value that advances once for every rising edge of a slow reference clock. The reference is sampled in the bus clock domain through a two-flop synchroniser and an edge detector, so the counter and all register state live in one clock domain. Software starts and stops counting with an enable bit and can record which oscillator feeds the reference through a two-bit source field. Software can never write or clear the counter, so its value never goes down.

A 64-bit comparator raises a level interrupt once the counter reaches or passes it. The interrupt then stays high until software writes the comparator, which makes it suitable for periodic wakeups: each handler writes the next deadline. A parameter selects the bus data width. With 64 bits the counter and comparator are single registers. With 32 bits each is split into a low word and a high word.

Top module: `rt_counter_top`

## Requirements
- R1: After reset the control register at offset 0x00 reads 0x6 (bit 0 = enable = 0, bits [2:1] = source = 2'b11), the counter reads 0 and irq_o is 0.
- R2: A write to offset 0x00 stores bit 0 as enable and bits [2:1] as source (00 external reference, 01 reserved, 10 trimmed on-chip oscillator, 11 crystal). Bits [31:3] are ignored and read 0.
- R3: With enable = 1, each rising edge of ref_clk_i adds exactly 1 to the counter. The edge passes a two-flop synchroniser and an edge detector, so the new value is readable three clk_i edges after the first edge that samples ref_clk_i high.
- R4: With enable = 0 the counter holds its value whatever ref_clk_i does.
- R5: Writes to the counter offsets (0x08, and 0x0C in 32-bit mode) have no effect on the counter.
- R6: dbg_halt_i has no effect: counting goes on while it is high.
- R7: The comparator is read/write at offset 0x10 in 64-bit mode and reads back the value written.
- R8: irq_o goes high on the clk_i edge after any cycle in which counter >= comparator.
- R9: Once high, irq_o stays high until a comparator write, which clears it on that edge. On the following edge the comparison is made again against the new value, so irq_o returns at once if the counter is already at or past it.
- R10: In 32-bit mode the counter low/high words read at 0x08/0x0C and the comparator low/high words are read/write at 0x10/0x14. A write to either comparator word clears irq_o.
- R11: Unmapped offsets (for example 0x04 and 0x18, and 0x0C in 64-bit mode) read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Slow reference clock, sampled as data |
| dbg_halt_i | input | 1 | Debug halt indication, does not gate counting |
| req_valid_i | input | 1 | Register access valid this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address of the register |
| req_wdata_i | input | DATA_W | Write data |
| rsp_rdata_o | output | DATA_W | Read data, valid in the same cycle as the request, 0 when idle |
| irq_o | output | 1 | Sticky compare interrupt |

## Verification
If the synchroniser or the edge detector drops or doubles a tick, the counter drifts away from the reference model. The next counter read shows this, a few hundred cycles after the edge at most. If the interrupt state is wrong, for example not sticky, not cleared by a comparator write, or not raised again after one, the every-cycle irq_o comparison catches it on the first clock edge where it differs. A wrong address decode or a wrong split between words shows up as a wrong value on the first read of that offset, or as a counter or comparator changed by a write that should have been ignored.

// File: rtl/rt_counter_pkg.sv
package rt_counter_pkg;

  typedef enum logic [1:0] {
    SRC_EXT_REF  = 2'b00,
    SRC_RSVD     = 2'b01,
    SRC_TRIM_OSC = 2'b10,
    SRC_XTAL     = 2'b11
  } src_sel_e;

  typedef struct packed {
    src_sel_e src;
    logic     en;
  } ctrl_t;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_CNT_LO = 8'h08;
  localparam logic [7:0] OFF_CNT_HI = 8'h0C;
  localparam logic [7:0] OFF_CMP_LO = 8'h10;
  localparam logic [7:0] OFF_CMP_HI = 8'h14;

endpackage

// File: rtl/rt_tick_sync.sv
module rt_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic tick_o
);
  // sh[SYNC_STAGES-1] is the synchronised level, sh[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], ref_i};
  end

  assign tick_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // one pulse per reference edge
  p_tick_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/rt_count_core.sv
module rt_count_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [1:0]       cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             irq_o
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [HALF-1:0]  cmp_half_q [2];
  logic [CNT_W-1:0] cmp_w;
  logic             irq_q;
  logic             hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (tick_i && en_i)    cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar h = 0; h < 2; h++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cmp_half_q[h] <= '0;
      else if (cmp_we_i[h]) cmp_half_q[h] <= cmp_wdata_i[h*HALF +: HALF];
    end
  end

  assign cmp_w = {cmp_half_q[1], cmp_half_q[0]};
  assign hit   = cnt_q >= cmp_w;

  // comparator write wins; compare restarts next cycle against new value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (|cmp_we_i) irq_q <= 1'b0;
    else               irq_q <= irq_q | hit;
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_w;
  assign irq_o = irq_q;

  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && en_i) |=> $stable(cnt_q));
  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(cnt_q >= cmp_w));
  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !(|cmp_we_i)) |=> irq_q);
  p_irq_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmp_we_i) |=> !irq_q);

endmodule

// File: rtl/rt_reg_port.sv
module rt_reg_port
  import rt_counter_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_i,
  output ctrl_t             ctrl_o,
  output logic [1:0]        cmp_we_o,
  output logic [CNT_W-1:0]  cmp_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int  HALF = CNT_W / 2;
  localparam bit  WIDE = (DATA_W == CNT_W);

  ctrl_t             ctrl_q;
  logic              wr;
  logic              ctrl_we;
  logic [DATA_W-1:0] rd_c;

  assign wr      = valid_i & write_i;
  assign ctrl_we = wr && (addr_i == ADDR_W'(OFF_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{src: SRC_XTAL, en: 1'b0};
    end else if (ctrl_we) begin
      ctrl_q.en  <= wdata_i[0];
      ctrl_q.src <= src_sel_e'(wdata_i[2:1]);
    end
  end

  if (WIDE) begin : g_wide
    always_comb begin
      cmp_we_o    = {2{wr && (addr_i == ADDR_W'(OFF_CMP_LO))}};
      cmp_wdata_o = CNT_W'(wdata_i);
      unique case (addr_i)
        ADDR_W'(OFF_CTRL):   rd_c = DATA_W'(ctrl_q);
        ADDR_W'(OFF_CNT_LO): rd_c = DATA_W'(cnt_i);
        ADDR_W'(OFF_CMP_LO): rd_c = DATA_W'(cmp_i);
        default:             rd_c = '0;
      endcase
    end
  end else begin : g_split
    always_comb begin
      cmp_we_o[0] = wr && (addr_i == ADDR_W'(OFF_CMP_LO));
      cmp_we_o[1] = wr && (addr_i == ADDR_W'(OFF_CMP_HI));
      cmp_wdata_o = {2{HALF'(wdata_i)}};
      unique case (addr_i)
        ADDR_W'(OFF_CTRL):   rd_c = DATA_W'(ctrl_q);
        ADDR_W'(OFF_CNT_LO): rd_c = DATA_W'(cnt_i[HALF-1:0]);
        ADDR_W'(OFF_CNT_HI): rd_c = DATA_W'(cnt_i[CNT_W-1:HALF]);
        ADDR_W'(OFF_CMP_LO): rd_c = DATA_W'(cmp_i[HALF-1:0]);
        ADDR_W'(OFF_CMP_HI): rd_c = DATA_W'(cmp_i[CNT_W-1:HALF]);
        default:             rd_c = '0;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = valid_i ? rd_c : '0;

  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> $stable(ctrl_q));
  p_ctrl_rsvd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !write_i && addr_i == ADDR_W'(OFF_CTRL)) |-> rdata_o[DATA_W-1:3] == '0);

endmodule

// File: rtl/rt_counter_top.sv
module rt_counter_top
  import rt_counter_pkg::*;
#(
  parameter int CNT_W       = 64,
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              dbg_halt_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  logic             tick;
  ctrl_t            ctrl;
  logic [1:0]       cmp_we;
  logic [CNT_W-1:0] cmp_wdata;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;

  rt_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ref_i (ref_clk_i),
    .tick_o(tick)
  );

  rt_reg_port #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (req_valid_i),
    .write_i    (req_write_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .cnt_i      (cnt),
    .cmp_i      (cmp),
    .ctrl_o     (ctrl),
    .cmp_we_o   (cmp_we),
    .cmp_wdata_o(cmp_wdata),
    .rdata_o    (rsp_rdata_o)
  );

  rt_count_core #(.CNT_W(CNT_W)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .en_i       (ctrl.en),
    .cmp_we_i   (cmp_we),
    .cmp_wdata_i(cmp_wdata),
    .cnt_o      (cnt),
    .cmp_o      (cmp),
    .irq_o      (irq_o)
  );

  // halt must not gate counting
  p_halt_counts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_halt_i && tick && ctrl.en) |=> cnt != $past(cnt));
  // counter offsets are read-only
  p_cnt_ro_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !tick) |=> $stable(cnt));

endmodule

// File: tb/test_rt_counter_top.sv
module test_rt_counter_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic        halt = 1'b0;
  logic        ref_run = 1'b0;
  logic        b_valid [2];
  logic        b_write [2];
  logic [7:0]  b_addr  [2];
  logic [63:0] b_wdata [2];
  logic [63:0] rd64;
  logic [31:0] rd32;
  logic        irq [2];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rt_counter_top #(.DATA_W(64)) i_rt_counter_top (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .dbg_halt_i(halt),
    .req_valid_i(b_valid[0]), .req_write_i(b_write[0]), .req_addr_i(b_addr[0]),
    .req_wdata_i(b_wdata[0]), .rsp_rdata_o(rd64), .irq_o(irq[0]));

  rt_counter_top #(.DATA_W(32)) i_rt_counter_top_w32 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .dbg_halt_i(halt),
    .req_valid_i(b_valid[1]), .req_write_i(b_write[1]), .req_addr_i(b_addr[1]),
    .req_wdata_i(b_wdata[1][31:0]), .rsp_rdata_o(rd32), .irq_o(irq[1]));

  // reference model
  typedef struct {
    bit        en;
    bit [1:0]  src;
    bit [63:0] cnt;
    bit [63:0] cmp;
    bit        irq;
  } mstate_t;

  mstate_t m [2];
  bit sync_q [$];

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mread(int i, logic [7:0] a);
    if (a == 8'h00) return {61'b0, m[i].src, m[i].en};
    if (i == 0) begin
      if (a == 8'h08) return m[i].cnt;
      if (a == 8'h10) return m[i].cmp;
      return 64'b0;
    end
    case (a)
      8'h08:   return {32'b0, m[i].cnt[31:0]};
      8'h0C:   return {32'b0, m[i].cnt[63:32]};
      8'h10:   return {32'b0, m[i].cmp[31:0]};
      8'h14:   return {32'b0, m[i].cmp[63:32]};
      default: return 64'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) m[i] = '{en: 0, src: 2'b11, cnt: 0, cmp: 0, irq: 0};
      sync_q = '{0, 0, 0};
    end else begin
      bit tk;
      tk = sync_q[1] && !sync_q[2];
      for (int i = 0; i < 2; i++) begin
        bit cw;
        bit hit;
        cw  = b_valid[i] && b_write[i] && (b_addr[i] == 8'h10 || (i == 1 && b_addr[i] == 8'h14));
        hit = m[i].cnt >= m[i].cmp;
        m[i].irq = cw ? 1'b0 : (m[i].irq | hit);
        if (tk && m[i].en) m[i].cnt++;
        if (b_valid[i] && b_write[i]) begin
          if (b_addr[i] == 8'h00) begin
            m[i].en  = b_wdata[i][0];
            m[i].src = b_wdata[i][2:1];
          end else if (b_addr[i] == 8'h10) begin
            if (i == 0) m[i].cmp = b_wdata[i];
            else        m[i].cmp[31:0] = b_wdata[i][31:0];
          end else if (b_addr[i] == 8'h14 && i == 1) begin
            m[i].cmp[63:32] = b_wdata[i][31:0];
          end
        end
      end
      sync_q.push_front(ref_clk);
      void'(sync_q.pop_back());
    end
  end

  // per-cycle interrupt comparison
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) check(irq[i] == 1'b0, "R1 irq in reset", 64'(irq[i]), 0);
      else        check(irq[i] == m[i].irq, "R8/R9 irq", 64'(irq[i]), 64'(m[i].irq));
    end
  end

  // reference clock: period 8 bus cycles
  int div = 0;
  always @(negedge clk) begin
    if (ref_run) begin
      div++;
      if (div == 4) begin
        ref_clk <= ~ref_clk;
        div = 0;
      end
    end
  end

  task automatic wr(int i, logic [7:0] a, logic [63:0] d);
    @(negedge clk);
    b_valid[i] = 1; b_write[i] = 1; b_addr[i] = a; b_wdata[i] = d;
    @(negedge clk);
    b_valid[i] = 0; b_write[i] = 0;
  endtask

  task automatic rd(int i, logic [7:0] a, string req, output logic [63:0] got);
    logic [63:0] exp;
    @(negedge clk);
    b_valid[i] = 1; b_write[i] = 0; b_addr[i] = a;
    #1;
    got = (i == 0) ? rd64 : {32'b0, rd32};
    exp = mread(i, a);
    check(got == exp, req, got, exp);
    b_valid[i] = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_tests();
    logic [63:0] v;
    logic [63:0] held;
    for (int i = 0; i < 2; i++) begin
      b_valid[i] = 0; b_write[i] = 0; b_addr[i] = 0; b_wdata[i] = 0;
    end
    idle(3);
    rst_n = 1;
    // R1 reset values
    for (int i = 0; i < 2; i++) begin
      rd(i, 8'h00, "R1 ctrl reset", v);
      check(v == 64'h6, "R1 ctrl reset literal", v, 64'h6);
      rd(i, 8'h08, "R1 cnt reset", v);
    end
    // R2 control fields and reserved bits
    for (int i = 0; i < 2; i++) begin
      wr(i, 8'h00, 64'hFFFF_FFF9);
      rd(i, 8'h00, "R2 ctrl rsvd", v);
      check(v == 64'h1, "R2 ctrl rsvd literal", v, 64'h1);
      wr(i, 8'h00, 64'h5);
      rd(i, 8'h00, "R2 ctrl src", v);
    end
    // R7 / R10 comparator
    wr(0, 8'h10, 64'd40);
    rd(0, 8'h10, "R7 cmp readback", v);
    wr(1, 8'h10, 64'd40);
    wr(1, 8'h14, 64'd0);
    rd(1, 8'h10, "R10 cmp lo", v);
    // R3 / R6 counting with halt active
    halt = 1;
    ref_run = 1;
    idle(100);
    for (int i = 0; i < 2; i++) rd(i, 8'h08, "R3 R6 count", v);
    check(m[0].cnt > 0, "R6 progress under halt", m[0].cnt, 1);
    // R5 counter writes ignored
    wr(0, 8'h08, 64'h0);
    wr(1, 8'h08, 64'h0);
    wr(1, 8'h0C, 64'hFFFF_FFFF);
    for (int i = 0; i < 2; i++) rd(i, 8'h08, "R5 cnt ro", v);
    rd(1, 8'h0C, "R5 cnt hi ro", v);
    // R8 reach comparator, then sticky
    idle(300);
    check(m[0].irq == 1, "R8 model reached", 64'(m[0].irq), 1);
    idle(20);
    // R9 clear by writing far-ahead value
    wr(0, 8'h10, m[0].cnt + 64'd1000);
    wr(1, 8'h14, 64'd1);
    idle(5);
    // R9 write past value: clear then reassert
    wr(0, 8'h10, 64'd0);
    wr(1, 8'h14, 64'd0);
    idle(5);
    // R4 disable
    for (int i = 0; i < 2; i++) wr(i, 8'h00, 64'h4);
    rd(0, 8'h08, "R4 cnt before", held);
    idle(60);
    rd(0, 8'h08, "R4 cnt hold", v);
    check(v == held, "R4 cnt unchanged", v, held);
    rd(1, 8'h08, "R4 cnt hold w32", v);
    // R11 unmapped offsets
    rd(0, 8'h04, "R11 unmapped 0x04", v);
    rd(0, 8'h18, "R11 unmapped 0x18", v);
    rd(0, 8'h0C, "R11 unmapped 0x0C wide", v);
    rd(1, 8'h18, "R11 unmapped w32", v);
    wr(0, 8'h18, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(0, 8'h0C, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(0, 8'h10, "R11 cmp untouched", v);
    rd(0, 8'h00, "R11 ctrl untouched", v);
    // R10 split words
    wr(1, 8'h14, 64'd1);
    wr(1, 8'h10, 64'h1234_5678);
    rd(1, 8'h14, "R10 cmp hi", v);
    check(v == 64'd1, "R10 cmp hi literal", v, 1);
    rd(1, 8'h10, "R10 cmp lo literal path", v);
    rd(1, 8'h0C, "R10 cnt hi", v);
    rd(1, 8'h08, "R10 cnt lo", v);
    idle(5);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule